// File: doc/BRIEF.md
# I2C Master with Internal-Address Phase

This block is a single-byte I2C controller for the master side of a two-wire bus. A host loads a 7-bit device address, a direction, an address length of zero to three bytes, a 24-bit address word and a write byte, then pulses a start strobe. The block then runs the whole transfer with no further help. It generates the START, any repeated START and the STOP, shifts each byte on the bus and checks every acknowledge. It drives the open-drain clock and data lines only by pulling them low through output enables, and it reads the data line back.

A write sends the device byte with a write bit, then the selected low-order address bytes with the most significant first, then the data byte. A read with a non-zero address length sends the same address phase. It then turns the bus round with a repeated START and a second device byte that carries the read bit. It takes in one byte and answers it with a NACK. When the address length is zero, the device byte follows START directly in either direction.

The same address field can carry the extra bits of a wider slave address. Those bits then go out as ordinary address bytes right after the first device byte. When a slave refuses any byte the master sends, the block flags the error and ends the transfer with STOP.

Top module: `i2c_ia_master`

## Requirements
- R1: After reset, both line enables are low (SCL and SDA released), `done` is 0 and `nack_err` is 0.
- R2: Within a transfer, SCL falls exactly every 4*QDIV clocks. During a data or acknowledge bit, SDA changes only while SCL is low. SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP.
- R3: With `ia_size`=0, a write puts on the bus START, `{dev_addr,0}`, `wr_data`, STOP. A read puts on the bus START, `{dev_addr,1}`, then the slave's byte, then STOP, with no repeated START. The direction bit is the LSB of the device byte: 0 means write and 1 means read.
- R4: With `ia_size`=N (1 to 3), N address bytes follow the device-write byte, each acknowledged. Byte k (k=1..N) is `int_addr[8*(N-k)+7 : 8*(N-k)]`, so the most significant selected byte goes first. Every byte is sent MSB first.
- R5: A write with an address phase sends `wr_data` after the last address byte and then STOP. The bus sees exactly N+2 bytes and one START.
- R6: A read with N greater than 0 sends a repeated START after the address bytes, then `{dev_addr,1}`. It then receives one byte MSB first and leaves SDA released (NACK) on its ninth clock. The received byte is on `rd_data` from the `done` pulse and stays there, unchanged while idle, until the next start.
- R7: If the slave leaves SDA high in the acknowledge slot of any device, address or write-data byte, the master sets `nack_err`. It sends STOP and sends no further byte.
- R8: `done` is high for exactly one clock after STOP, with both lines released. `nack_err` is valid at `done` and returns to 0 when the next transfer starts.
- R9: A start strobe that arrives while a transfer is running is ignored. The running transfer keeps its own settings, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock strobe that begins a transfer when idle |
| dev_addr | input | 7 | Slave device address |
| ia_size | input | 2 | Number of internal address bytes, 0 to 3 |
| int_addr | input | 24 | Internal address word; the low ia_size bytes are sent |
| rd_not_wr | input | 1 | 1 selects a read, 0 a write |
| wr_data | input | 8 | Byte written in a write transfer |
| rd_data | output | 8 | Byte received in the last read transfer |
| done | output | 1 | One-clock pulse at the end of a transfer |
| nack_err | output | 1 | The last transfer was refused by the slave |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The assertions assume that `sda_in` changes only while the block holds SCL low, except for the levels that the block itself drives. They also assume that nothing but the block moves SCL, since there is no clock stretching and no second master. The bench's slave model respects this: it changes its pull-down only when it sees SCL fall, and it releases SDA before the master's next symbol. The random stimulus picks the address length, the address word and the data freely. It never raises a start strobe while a transfer runs, except in the one directed case that checks such a strobe is ignored.

// File: rtl/i2c_ia_pkg.sv
package i2c_ia_pkg;

    localparam int IA_BYTES = 3;
    localparam int IA_W     = 8 * IA_BYTES;
    localparam int IA_CW    = $clog2(IA_BYTES + 1);
    localparam int DEV_W    = 7;

    // bus symbols executed by the bit engine, each four quarter periods long
    typedef enum logic [1:0] {
        SYM_START = 2'd0,
        SYM_STOP  = 2'd1,
        SYM_BIT   = 2'd2
    } sym_t;

    typedef enum logic [2:0] {
        BK_DEVW = 3'd0,
        BK_IADR = 3'd1,
        BK_WDAT = 3'd2,
        BK_DEVR = 3'd3,
        BK_RDAT = 3'd4
    } byte_kind_t;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_START  = 3'd1,
        SQ_BYTE   = 3'd2,
        SQ_RSTART = 3'd3,
        SQ_STOP   = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [IA_CW-1:0] ia_size;
        logic [IA_W-1:0]  ia;
        logic             rd;
        logic [7:0]       wdat;
    } xfer_cfg_t;

    // address byte that is still to go when 'left' bytes remain (1 = lowest byte)
    function automatic logic [7:0] ia_byte_sel(logic [IA_W-1:0] ia, logic [IA_CW-1:0] left);
        int unsigned k;
        k = (left == '0) ? 0 : int'(left) - 1;
        return ia[8*k +: 8];
    endfunction

endpackage

// File: rtl/i2c_ia_tick.sv
module i2c_ia_tick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(QDIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_ia_phy.sv
module i2c_ia_phy
    import i2c_ia_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cmd_go,
    input  sym_t cmd_sym,
    input  logic cmd_bit,
    input  logic sda_in,
    output logic cmd_done,
    output logic rx_bit,
    output logic scl_rel,
    output logic sda_rel
);
    logic       busy;
    logic [1:0] q;
    sym_t       sym;
    logic       bitv;
    logic [1:0] sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_s <= 2'b11;
        end else begin
            sda_s <= {sda_s[0], sda_in};
        end
    end

    // every symbol: q0 SCL low, q1 first SDA level, q2 SCL high, q3 second SDA level or sample
    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            q        <= 2'd0;
            sym      <= SYM_BIT;
            bitv     <= 1'b1;
            scl_rel  <= 1'b1;
            sda_rel  <= 1'b1;
            cmd_done <= 1'b0;
            rx_bit   <= 1'b1;
        end else begin
            cmd_done <= 1'b0;
            if (!busy && cmd_go) begin
                busy <= 1'b1;
                q    <= 2'd0;
                sym  <= cmd_sym;
                bitv <= cmd_bit;
            end else if (busy && tick) begin
                q <= q + 2'd1;
                unique case (q)
                    2'd0: scl_rel <= 1'b0;
                    2'd1: begin
                        unique case (sym)
                            SYM_START: sda_rel <= 1'b1;
                            SYM_STOP:  sda_rel <= 1'b0;
                            default:   sda_rel <= bitv;
                        endcase
                    end
                    2'd2: scl_rel <= 1'b1;
                    default: begin
                        busy     <= 1'b0;
                        cmd_done <= 1'b1;
                        unique case (sym)
                            SYM_START: sda_rel <= 1'b0;
                            SYM_STOP:  sda_rel <= 1'b1;
                            default:   rx_bit  <= sda_s[1];
                        endcase
                    end
                endcase
            end
        end
    end

    // R2: data and acknowledge bits never move SDA while SCL is high
    a_r2_sda_quiet_high: assert property (@(posedge clk) disable iff (rst)
        (busy && sym == SYM_BIT && scl_rel && $past(scl_rel)) |-> $stable(sda_rel));

    // R2: the sequencer only hands over a symbol when the engine is free
    a_r2_go_when_free: assert property (@(posedge clk) disable iff (rst)
        cmd_go |-> !busy);

endmodule

// File: rtl/i2c_ia_seq.sv
module i2c_ia_seq
    import i2c_ia_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  xfer_cfg_t cfg_in,
    input  logic      cmd_done,
    input  logic      rx_bit,
    output logic      cmd_go,
    output sym_t      cmd_sym,
    output logic      cmd_bit,
    output logic [7:0] rd_data,
    output logic      done,
    output logic      nack_err
);
    seq_state_t       st;
    byte_kind_t       kind;
    xfer_cfg_t        cfg;
    logic [IA_CW-1:0] ia_left;
    logic [3:0]       bitn;
    logic [7:0]       shreg;

    // what follows an acknowledged byte
    logic       nx_byte_go;
    logic       nx_rstart;
    byte_kind_t nx_kind;
    logic [7:0] nx_byte;

    always_comb begin
        nx_byte_go = 1'b1;
        nx_rstart  = 1'b0;
        nx_kind    = BK_WDAT;
        nx_byte    = cfg.wdat;
        unique case (kind)
            BK_DEVW, BK_IADR: begin
                if (ia_left != '0) begin
                    nx_kind = BK_IADR;
                    nx_byte = ia_byte_sel(cfg.ia, ia_left);
                end else if (cfg.rd) begin
                    nx_byte_go = 1'b0;
                    nx_rstart  = 1'b1;
                end
            end
            BK_DEVR: begin
                nx_kind = BK_RDAT;
                nx_byte = 8'hFF;
            end
            default: nx_byte_go = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            kind     <= BK_DEVW;
            cfg      <= '0;
            ia_left  <= '0;
            bitn     <= 4'd0;
            shreg    <= 8'hFF;
            cmd_go   <= 1'b0;
            cmd_sym  <= SYM_BIT;
            cmd_bit  <= 1'b1;
            rd_data  <= 8'h00;
            done     <= 1'b0;
            nack_err <= 1'b0;
        end else begin
            cmd_go <= 1'b0;
            done   <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    if (start) begin
                        cfg      <= cfg_in;
                        ia_left  <= cfg_in.ia_size;
                        nack_err <= 1'b0;
                        st       <= SQ_START;
                        cmd_go   <= 1'b1;
                        cmd_sym  <= SYM_START;
                    end
                end
                SQ_START: begin
                    if (cmd_done) begin
                        kind    <= (cfg.ia_size == '0 && cfg.rd) ? BK_DEVR : BK_DEVW;
                        shreg   <= {cfg.dev, cfg.rd && cfg.ia_size == '0};
                        bitn    <= 4'd0;
                        st      <= SQ_BYTE;
                        cmd_go  <= 1'b1;
                        cmd_sym <= SYM_BIT;
                        cmd_bit <= cfg.dev[DEV_W-1];
                    end
                end
                SQ_RSTART: begin
                    if (cmd_done) begin
                        kind    <= BK_DEVR;
                        shreg   <= {cfg.dev, 1'b1};
                        bitn    <= 4'd0;
                        st      <= SQ_BYTE;
                        cmd_go  <= 1'b1;
                        cmd_sym <= SYM_BIT;
                        cmd_bit <= cfg.dev[DEV_W-1];
                    end
                end
                SQ_BYTE: begin
                    if (cmd_done) begin
                        if (bitn != 4'd8) begin
                            shreg   <= {shreg[6:0], rx_bit};
                            bitn    <= bitn + 4'd1;
                            cmd_go  <= 1'b1;
                            cmd_sym <= SYM_BIT;
                            cmd_bit <= (bitn == 4'd7) ? 1'b1 : shreg[6];
                        end else if (kind == BK_RDAT) begin
                            rd_data <= shreg;
                            st      <= SQ_STOP;
                            cmd_go  <= 1'b1;
                            cmd_sym <= SYM_STOP;
                        end else if (rx_bit) begin
                            nack_err <= 1'b1;
                            st       <= SQ_STOP;
                            cmd_go   <= 1'b1;
                            cmd_sym  <= SYM_STOP;
                        end else if (nx_byte_go) begin
                            kind    <= nx_kind;
                            shreg   <= nx_byte;
                            bitn    <= 4'd0;
                            cmd_go  <= 1'b1;
                            cmd_sym <= SYM_BIT;
                            cmd_bit <= nx_byte[7];
                            if (nx_kind == BK_IADR) begin
                                ia_left <= ia_left - 1'b1;
                            end
                        end else if (nx_rstart) begin
                            st      <= SQ_RSTART;
                            cmd_go  <= 1'b1;
                            cmd_sym <= SYM_START;
                        end else begin
                            st      <= SQ_STOP;
                            cmd_go  <= 1'b1;
                            cmd_sym <= SYM_STOP;
                        end
                    end
                end
                default: begin
                    if (cmd_done) begin
                        st   <= SQ_IDLE;
                        done <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R8: completion is a single-clock pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: never more address bytes outstanding than were asked for
    a_r4_ia_bound: assert property (@(posedge clk) disable iff (rst)
        ia_left <= cfg.ia_size);

endmodule

// File: rtl/i2c_ia_master.sv
module i2c_ia_master
    import i2c_ia_pkg::*;
#(
    parameter int QDIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DEV_W-1:0] dev_addr,
    input  logic [IA_CW-1:0] ia_size,
    input  logic [IA_W-1:0]  int_addr,
    input  logic             rd_not_wr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             nack_err,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in
);
    logic      tick;
    logic      cmd_go;
    sym_t      cmd_sym;
    logic      cmd_bit;
    logic      cmd_done;
    logic      rx_bit;
    logic      scl_rel;
    logic      sda_rel;
    xfer_cfg_t cfg_in;

    assign cfg_in = '{dev: dev_addr, ia_size: ia_size, ia: int_addr,
                      rd: rd_not_wr, wdat: wr_data};

    i2c_ia_tick #(.QDIV(QDIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    i2c_ia_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cfg_in   (cfg_in),
        .cmd_done (cmd_done),
        .rx_bit   (rx_bit),
        .cmd_go   (cmd_go),
        .cmd_sym  (cmd_sym),
        .cmd_bit  (cmd_bit),
        .rd_data  (rd_data),
        .done     (done),
        .nack_err (nack_err)
    );

    i2c_ia_phy u_phy (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmd_go   (cmd_go),
        .cmd_sym  (cmd_sym),
        .cmd_bit  (cmd_bit),
        .sda_in   (sda_in),
        .cmd_done (cmd_done),
        .rx_bit   (rx_bit),
        .scl_rel  (scl_rel),
        .sda_rel  (sda_rel)
    );

    assign scl_oe = ~scl_rel;
    assign sda_oe = ~sda_rel;

    // R8: completion is only reported with both lines let go
    a_r8_done_released: assert property (@(posedge clk) disable iff (rst)
        done |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/i2c_ia_master_tb.sv
module i2c_ia_master_tb;
    localparam int QDIV = 4;
    localparam logic [6:0] SLV = 7'h52;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        start = 1'b0;
    logic [6:0]  dev_addr = '0;
    logic [1:0]  ia_size = '0;
    logic [23:0] int_addr = '0;
    logic        rd_not_wr = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        done, nack_err, scl_oe, sda_oe;
    logic        slv_pull;
    logic        scl_w, sda_w;

    assign scl_w = !scl_oe;
    assign sda_w = !(sda_oe || slv_pull);

    i2c_ia_master #(.QDIV(QDIV)) u_dut (
        .clk(clk), .rst(rst), .start(start), .dev_addr(dev_addr),
        .ia_size(ia_size), .int_addr(int_addr), .rd_not_wr(rd_not_wr),
        .wr_data(wr_data), .rd_data(rd_data), .done(done), .nack_err(nack_err),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
    );

    // ---------------- slave model with address pointer ----------------
    int         ia_n_slv = 0;
    int         nack_at = -1;
    logic [7:0] mem [256];
    logic [7:0] ptr;
    logic [7:0] log_b [8];
    int         log_n, n_start, n_stop, done_cnt;
    logic       mack_seen;
    int         r2_seen, r2_bad;
    longint     cyc, last_fall;
    logic       p_scl, p_sda, s_on, s_tx, s_go_tx, s_sel, mon_on;
    int         s_cnt, s_bidx;
    logic [7:0] s_sh, s_txb;

    always @(posedge clk) begin
        logic sc, sd, ack;
        cyc = cyc + 1;
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
            ptr = 8'h00; log_n = 0; n_start = 0; n_stop = 0; done_cnt = 0;
            p_scl = 1'b1; p_sda = 1'b1; s_on = 1'b0; s_tx = 1'b0; s_go_tx = 1'b0;
            s_sel = 1'b0; s_cnt = 0; s_bidx = 0; slv_pull <= 1'b0; mon_on = 1'b0;
            r2_seen = 0; r2_bad = 0; last_fall = -1; cyc = 0; mack_seen = 1'b0;
        end else begin
            sc = scl_w; sd = sda_w;
            if (done) done_cnt = done_cnt + 1;
            if (p_scl && !sc) begin
                if (mon_on && last_fall >= 0) begin
                    r2_seen = r2_seen + 1;
                    if (cyc - last_fall != 4 * QDIV) r2_bad = r2_bad + 1;
                end
                last_fall = cyc;
            end
            if (p_scl && sc && p_sda && !sd) begin
                if (!s_on) begin
                    log_n = 0; n_start = 0; n_stop = 0; mack_seen = 1'b0;
                end
                n_start = n_start + 1;
                s_on = 1'b1; s_cnt = 0; s_bidx = 0; s_tx = 1'b0; s_go_tx = 1'b0;
                s_sel = 1'b1; slv_pull <= 1'b0; mon_on = 1'b1;
            end else if (p_scl && sc && !p_sda && sd) begin
                n_stop = n_stop + 1;
                s_on = 1'b0; s_tx = 1'b0; slv_pull <= 1'b0; mon_on = 1'b0; last_fall = -1;
            end else if (s_on) begin
                if (!p_scl && sc) begin
                    if (s_cnt < 8) s_sh = {s_sh[6:0], sd};
                    else if (s_tx) begin
                        mack_seen = sd;
                        if (sd) begin s_tx = 1'b0; end
                    end
                    s_cnt = s_cnt + 1;
                end else if (p_scl && !sc) begin
                    if (s_cnt == 8 && !s_tx) begin
                        ack = 1'b1;
                        if (s_bidx == 0) begin
                            s_sel = (s_sh[7:1] == SLV);
                        end
                        if (!s_sel || s_bidx == nack_at) ack = 1'b0;
                        if (ack) begin
                            if (s_bidx == 0) s_go_tx = s_sh[0];
                            else if (s_bidx <= ia_n_slv) ptr = s_sh;
                            else mem[ptr] = s_sh;
                        end
                        if (log_n < 8) log_b[log_n] = s_sh;
                        log_n = log_n + 1;
                        s_bidx = s_bidx + 1;
                        slv_pull <= ack;
                    end else if (s_cnt == 9) begin
                        s_cnt = 0;
                        if (s_go_tx) begin
                            s_tx = 1'b1; s_go_tx = 1'b0; s_txb = mem[ptr];
                        end
                        slv_pull <= s_tx ? !s_txb[7] : 1'b0;
                    end else if (s_tx && s_cnt < 8) begin
                        slv_pull <= !s_txb[7 - s_cnt];
                    end else if (s_tx && s_cnt == 8) begin
                        slv_pull <= 1'b0;
                    end
                end
            end
            p_scl = sc; p_sda = sd;
        end
    end

    // ---------------- checking ----------------
    int total = 0;
    int bad = 0;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ia_exp_byte(logic [23:0] ia, int n, int k);
        return ia[8*(n-k) +: 8];
    endfunction

    task automatic xfer(input bit rd, input int n, input logic [23:0] ia,
                        input logic [7:0] d, input logic [6:0] dev);
        int wt;
        @(negedge clk);
        ia_n_slv = n;
        dev_addr = dev; ia_size = 2'(n); int_addr = ia; rd_not_wr = rd; wr_data = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wt = 0;
        while (!done && wt < 20000) begin @(negedge clk); wt++; end
        chk("R8 transfer completes", done, 1);
    endtask

    task automatic do_write(input int n, input logic [23:0] ia, input logic [7:0] d, input string tag);
        xfer(1'b0, n, ia, d, SLV);
        chk({tag, " nack clear"}, nack_err, 0);
        chk({tag, " byte count"}, log_n, n + 2);
        chk({tag, " single start"}, n_start, 1);
        chk({tag, " dev byte"}, log_b[0], {SLV, 1'b0});
        for (int k = 1; k <= n; k++) chk({tag, " R4 addr byte"}, log_b[k], ia_exp_byte(ia, n, k));
        chk({tag, " data byte"}, log_b[n+1], d);
        if (n > 0) exp_ptr = ia[7:0];
        exp_mem[exp_ptr] = d;
        @(negedge clk);
        chk({tag, " R8 done one clock"}, done, 0);
        chk({tag, " stop seen"}, n_stop, 1);
    endtask

    task automatic do_read(input int n, input logic [23:0] ia, input string tag);
        if (n > 0) exp_ptr = ia[7:0];
        xfer(1'b1, n, ia, 8'h00, SLV);
        chk({tag, " nack clear"}, nack_err, 0);
        chk({tag, " read data"}, rd_data, exp_mem[exp_ptr]);
        chk({tag, " R2 bus released at done"}, {scl_oe, sda_oe}, 0);
        if (n > 0) begin
            chk({tag, " R6 repeated start"}, n_start, 2);
            chk({tag, " R6 byte count"}, log_n, n + 2);
            chk({tag, " R6 read dev byte"}, log_b[n+1], {SLV, 1'b1});
            for (int k = 1; k <= n; k++) chk({tag, " R4 addr byte"}, log_b[k], ia_exp_byte(ia, n, k));
        end else begin
            chk({tag, " R3 no repeated start"}, n_start, 1);
            chk({tag, " R3 byte count"}, log_n, 1);
            chk({tag, " R3 read dev byte"}, log_b[0], {SLV, 1'b1});
        end
        chk({tag, " R6 master nack"}, mack_seen, 1);
    endtask

    initial begin
        logic [7:0]  held, dd;
        logic [23:0] ra;
        int          rn, dc;
        void'($urandom(32'd20511));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 scl released", scl_oe, 0);
        chk("R1 sda released", sda_oe, 0);
        chk("R1 done low", done, 0);
        chk("R1 nack low", nack_err, 0);

        // directed: no address phase
        do_write(0, 24'h0, 8'h3C, "R3 write size0");
        do_read(0, 24'h0, "R3 read size0");
        // directed: three byte address, distinct bytes
        do_write(3, 24'h123456, 8'h9A, "R5 write size3");
        do_read(3, 24'h123456, "R6 read size3");
        held = rd_data;
        repeat (60) @(negedge clk);
        chk("R6 rd_data held while idle", rd_data, held);
        do_write(1, 24'hFFFF01, 8'h00, "R5 write size1");
        do_read(1, 24'hFFFF01, "R6 read size1");
        do_write(2, 24'hAB80FF, 8'hFF, "R5 write size2");
        do_read(2, 24'hAB80FF, "R6 read size2");

        // random write-then-read
        for (int it = 0; it < 24; it++) begin
            rn = int'($urandom % 4);
            ra = 24'($urandom);
            dd = 8'($urandom);
            do_write(rn, ra, dd, "R5 random write");
            do_read(rn, ra, "R6 random read");
        end
        chk("R2 scl period in transfer", r2_bad, 0);
        chk("R2 periods observed", r2_seen > 100, 1);

        // R7: wrong device address, write and read
        xfer(1'b0, 2, 24'h000011, 8'h55, 7'h13);
        chk("R7 wrong dev nack", nack_err, 1);
        chk("R7 wrong dev bytes", log_n, 1);
        chk("R7 wrong dev stop", n_stop, 1);
        xfer(1'b1, 2, 24'h000011, 8'h00, 7'h13);
        chk("R7 wrong dev read nack", nack_err, 1);
        chk("R7 wrong dev read no rstart", n_start, 1);
        chk("R7 wrong dev read bytes", log_n, 1);
        // R7: nack on second address byte
        nack_at = 2;
        xfer(1'b0, 3, 24'h4455C1, 8'h66, SLV);
        nack_at = -1;
        chk("R7 addr nack flag", nack_err, 1);
        chk("R7 addr nack stops early", log_n, 3);
        // R7: nack on data byte, memory must keep its old value
        nack_at = 2;
        xfer(1'b0, 1, 24'h000077, 8'h5A, SLV);
        nack_at = -1;
        chk("R7 data nack flag", nack_err, 1);
        chk("R7 data nack stop", n_stop, 1);
        do_read(1, 24'h000077, "R7 data nack not stored");
        do_read(1, 24'h0000C1, "R7 addr nack not stored");
        chk("R8 nack cleared on next start", nack_err, 0);

        // R9: start strobe during a running transfer
        @(negedge clk);
        ia_n_slv = 2;
        dev_addr = SLV; ia_size = 2'd2; int_addr = 24'h00BE3D; rd_not_wr = 1'b0; wr_data = 8'hC7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        dev_addr = 7'h13; ia_size = 2'd0; rd_not_wr = 1'b1; wr_data = 8'h11;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dc = done_cnt;
        begin
            int wt = 0;
            while (!done && wt < 20000) begin @(negedge clk); wt++; end
        end
        exp_ptr = 8'h3D; exp_mem[8'h3D] = 8'hC7;
        chk("R9 first transfer intact", log_n, 4);
        chk("R9 data byte kept", log_b[3], 8'hC7);
        chk("R9 no nack", nack_err, 0);
        repeat (400) @(negedge clk);
        chk("R9 no second transfer", done_cnt - dc, 1);
        chk("R9 bus idle", scl_oe, 0);
        do_read(2, 24'h00BE3D, "R9 readback");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule